// File: doc/BRIEF.md
# Raster or Linear Timer with Interrupt Compare

This block is a free-running timer that advances once per clock of `clk_i`, and each advance counts two master clocks. It runs in one of two modes. In raster mode, a horizontal counter sweeps one video line and a vertical counter tracks lines within a frame. The number of lines per frame depends on the region input. In linear mode, the two counters form a single long binary count: the horizontal counter is the low part and the vertical counter is the high part.

Software programs a horizontal compare position in dots, where one dot is four master clocks, and a vertical compare line. Two enables select one of four compare modes. A match sets a sticky interrupt flag. While the timer interrupt enable is high, a match also re-arms the interrupt request. An acknowledge strobe clears the flag and disarms the request.

Top module: `raster_timer`

## Requirements
- R1: While `rst_ni` is low, `hcount_o`, `vcount_o`, `flag_o` and `irq_o` are 0, and the request is armed.
- R2: In raster mode (`linear_i`=0), each clock adds 2 to `hcount_o`. When the sum reaches H_PERIOD (default 1364), `hcount_o` becomes 0 and the vertical counter advances.
- R3: In raster mode, a vertical advance that reaches the line count sets `vcount_o` to 0. The line count is LINES_60 (default 262) when `region_i`=0 and LINES_50 (default 312) when `region_i`=1.
- R4: In linear mode, each clock adds 2 to the 11-bit horizontal counter. The carry out of bit 11 adds 1 to the 9-bit vertical counter, and both counters wrap at their widths.
- R5: The compare mode is {`ven_i`,`hen_i`}. Mode 00 never matches. Mode 01 matches when the new horizontal count equals `hcmp_i`*4. Mode 10 matches when the new vertical count equals `vcmp_i` and the new horizontal count is 0. Mode 11 matches when both counts match.
- R6: A match sets `flag_o` on the same clock edge that loads the matching counter values. `flag_o` then stays set until an acknowledge.
- R7: `irq_o` = `flag_o` AND `irq_en_i` AND armed. A match while `irq_en_i`=1 arms the request. A match while `irq_en_i`=0 sets the flag and leaves the armed state unchanged.
- R8: An acknowledge (`ack_i`=1 at an edge) clears `flag_o` and disarms the request. If a match happens at the same edge, the match takes precedence.
- R9: In raster mode, a horizontal compare position at or beyond H_PERIOD (for example `hcmp_i`=341 with defaults) never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock; one advance of two master clocks per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| linear_i | input | 1 | 1 selects linear mode, 0 selects raster mode |
| region_i | input | 1 | Line count select in raster mode: 0 = 60 Hz frame, 1 = 50 Hz frame |
| hen_i | input | 1 | Horizontal compare enable |
| ven_i | input | 1 | Vertical compare enable |
| hcmp_i | input | 9 | Horizontal compare position in dots |
| vcmp_i | input | 9 | Vertical compare line |
| irq_en_i | input | 1 | Timer interrupt enable |
| ack_i | input | 1 | Acknowledge: clears the flag and disarms the request |
| hcount_o | output | 11 | Horizontal counter in master clocks |
| vcount_o | output | 9 | Vertical counter |
| flag_o | output | 1 | Sticky timer match flag |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The counters and the flag are registered, so they show the effect of an edge one step after it, in the same cycle. `irq_o` also follows `irq_en_i` combinationally. The bench drives inputs on falling edges. A behavioural model advances on each rising edge, and the outputs are compared with the model shortly after that edge. At that point every registered result of the edge has settled and the inputs are still stable. Directed checks locate the vertical-only match at horizontal zero and confirm that an out-of-range horizontal compare position never matches. The bench uses shortened line and frame parameters so that whole frames fit in a short run.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  typedef enum logic [1:0] {
    CMP_OFF = 2'b00,
    CMP_H   = 2'b01,
    CMP_V   = 2'b10,
    CMP_HV  = 2'b11
  } cmp_mode_e;
endpackage

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
  parameter int H_W      = 11,
  parameter int V_W      = 9,
  parameter int STEP     = 2,
  parameter int H_PERIOD = 1364,
  parameter int LINES_60 = 262,
  parameter int LINES_50 = 312
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           linear_i,
  input  logic           region_i,
  output logic [H_W-1:0] h_q_o,
  output logic [V_W-1:0] v_q_o,
  output logic [H_W-1:0] h_d_o,
  output logic [V_W-1:0] v_d_o
);
  logic [H_W-1:0] h_q;
  logic [V_W-1:0] v_q;
  logic [H_W:0]   h_sum;
  logic [V_W:0]   v_inc;
  logic [V_W:0]   lines;
  logic           line_end;

  always_comb begin
    h_sum    = {1'b0, h_q} + (H_W+1)'(STEP);
    v_inc    = {1'b0, v_q} + (V_W+1)'(1);
    lines    = region_i ? (V_W+1)'(LINES_50) : (V_W+1)'(LINES_60);
    line_end = (h_sum >= (H_W+1)'(H_PERIOD));
    if (linear_i) begin
      h_d_o = h_sum[H_W-1:0];
      v_d_o = v_q + V_W'(h_sum[H_W]);
    end else begin
      h_d_o = line_end ? '0 : h_sum[H_W-1:0];
      if (!line_end)          v_d_o = v_q;
      else if (v_inc >= lines) v_d_o = '0;
      else                     v_d_o = v_inc[V_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d_o;
      v_q <= v_d_o;
    end
  end

  assign h_q_o = h_q;
  assign v_q_o = v_q;
endmodule

// File: rtl/rtmr_compare.sv
module rtmr_compare
  import rtmr_pkg::*;
#(
  parameter int H_W       = 11,
  parameter int V_W       = 9,
  parameter int HC_W      = 9,
  parameter int DOT_SHIFT = 2
) (
  input  logic            hen_i,
  input  logic            ven_i,
  input  logic [HC_W-1:0] hcmp_i,
  input  logic [V_W-1:0]  vcmp_i,
  input  logic [H_W-1:0]  h_d_i,
  input  logic [V_W-1:0]  v_d_i,
  output logic            match_o
);
  localparam int TW = HC_W + DOT_SHIFT;
  localparam int CW = (TW > H_W) ? TW : H_W;

  cmp_mode_e      mode;
  logic [CW-1:0]  h_tgt;
  logic           h_hit, v_hit, h_zero;

  always_comb begin
    mode   = cmp_mode_e'({ven_i, hen_i});
    h_tgt  = CW'(hcmp_i) << DOT_SHIFT;   // dots to clocks
    h_hit  = (CW'(h_d_i) == h_tgt);
    v_hit  = (v_d_i == vcmp_i);
    h_zero = (h_d_i == '0);
    unique case (mode)
      CMP_OFF: match_o = 1'b0;
      CMP_H:   match_o = h_hit;
      CMP_V:   match_o = v_hit & h_zero;
      CMP_HV:  match_o = v_hit & h_hit;
      default: match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtmr_irq.sv
module rtmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic irq_en_i,
  input  logic ack_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (match_i)    flag_q <= 1'b1;
      else if (ack_i) flag_q <= 1'b0;
      if (match_i && irq_en_i) armed_q <= 1'b1;
      else if (ack_i)          armed_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i & armed_q;
endmodule

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int H_W       = 11,
  parameter int V_W       = 9,
  parameter int HC_W      = 9,
  parameter int DOT_SHIFT = 2,
  parameter int STEP      = 2,
  parameter int H_PERIOD  = 1364,
  parameter int LINES_60  = 262,
  parameter int LINES_50  = 312
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            linear_i,
  input  logic            region_i,
  input  logic            hen_i,
  input  logic            ven_i,
  input  logic [HC_W-1:0] hcmp_i,
  input  logic [V_W-1:0]  vcmp_i,
  input  logic            irq_en_i,
  input  logic            ack_i,
  output logic [H_W-1:0]  hcount_o,
  output logic [V_W-1:0]  vcount_o,
  output logic            flag_o,
  output logic            irq_o
);
  logic [H_W-1:0] h_d;
  logic [V_W-1:0] v_d;
  logic           match_w;

  rtmr_counter #(
    .H_W(H_W), .V_W(V_W), .STEP(STEP), .H_PERIOD(H_PERIOD),
    .LINES_60(LINES_60), .LINES_50(LINES_50)
  ) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .linear_i(linear_i),
    .region_i(region_i),
    .h_q_o   (hcount_o),
    .v_q_o   (vcount_o),
    .h_d_o   (h_d),
    .v_d_o   (v_d)
  );

  // compare looks at the post-step counter values
  rtmr_compare #(
    .H_W(H_W), .V_W(V_W), .HC_W(HC_W), .DOT_SHIFT(DOT_SHIFT)
  ) u_compare (
    .hen_i  (hen_i),
    .ven_i  (ven_i),
    .hcmp_i (hcmp_i),
    .vcmp_i (vcmp_i),
    .h_d_i  (h_d),
    .v_d_i  (v_d),
    .match_o(match_w)
  );

  rtmr_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (match_w),
    .irq_en_i(irq_en_i),
    .ack_i   (ack_i),
    .flag_o  (flag_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
  parameter int H_W      = 11,
  parameter int V_W      = 9,
  parameter int H_PERIOD = 1364
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           linear_i,
  input logic           hen_i,
  input logic           ven_i,
  input logic           irq_en_i,
  input logic           ack_i,
  input logic [H_W-1:0] hcount_o,
  input logic [V_W-1:0] vcount_o,
  input logic           flag_o,
  input logic           irq_o,
  input logic           match_w
);
  AST_H_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o[0] == 1'b0);  // R2
  AST_RASTER_H_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !linear_i |=> (32'(hcount_o) < H_PERIOD));  // R2
  AST_V_HOLD_MIDLINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(linear_i) && hcount_o != '0) |-> $stable(vcount_o));  // R3
  AST_MODE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hen_i && !ven_i) |-> !match_w);  // R5
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_w |=> flag_o);  // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !ack_i) |=> flag_o);  // R6
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));  // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !match_w) |=> !flag_o);  // R8
endmodule

bind raster_timer raster_timer_chk #(
  .H_W(H_W), .V_W(V_W), .H_PERIOD(H_PERIOD)
) u_chk (.*);

// File: tb/raster_timer_bench.sv
`timescale 1ns/1ps
module raster_timer_bench;
  localparam int HP  = 40;
  localparam int L60 = 6;
  localparam int L50 = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       linear = 1'b0, region = 1'b0, hen = 1'b0, ven = 1'b0;
  logic [8:0] hcmp = '0, vcmp = '0;
  logic       irq_en = 1'b0, ack = 1'b0;
  logic [10:0] hcount;
  logic [8:0]  vcount;
  logic        flag, irq;

  int checks = 0;
  int errors = 0;
  int m_h = 0, m_v = 0, m_flag = 0, m_armed = 1;

  always #2.5 clk = ~clk;

  raster_timer #(.H_PERIOD(HP), .LINES_60(L60), .LINES_50(L50)) u_raster_timer (
    .clk_i(clk), .rst_ni(rst_n), .linear_i(linear), .region_i(region),
    .hen_i(hen), .ven_i(ven), .hcmp_i(hcmp), .vcmp_i(vcmp),
    .irq_en_i(irq_en), .ack_i(ack),
    .hcount_o(hcount), .vcount_o(vcount), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_flag = 0; m_armed = 1;
    end else begin
      int lines;
      bit hit;
      lines = region ? L50 : L60;
      m_h = m_h + 2;
      if (!linear) begin
        if (m_h >= HP) begin
          m_h = 0;
          m_v = m_v + 1;
          if (m_v >= lines) m_v = 0;
        end
      end else begin
        m_v = (m_v + (m_h / 2048)) % 512;
        m_h = m_h % 2048;
      end
      case ({ven, hen})
        2'b01:   hit = (m_h == hcmp * 4);
        2'b10:   hit = (m_v == vcmp) && (m_h == 0);
        2'b11:   hit = (m_v == vcmp) && (m_h == hcmp * 4);
        default: hit = 1'b0;
      endcase
      if (hit) m_flag = 1; else if (ack) m_flag = 0;
      if (hit && irq_en) m_armed = 1; else if (ack) m_armed = 0;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(linear ? "R4 hcount" : "R2 hcount", int'(hcount), m_h);
      chk(linear ? "R4 vcount" : "R3 vcount", int'(vcount), m_v);
      chk("R5 R6 R8 flag", int'(flag), m_flag);
      chk("R7 R8 irq", int'(irq), m_flag & int'(irq_en) & m_armed);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rises;
    #12;
    // R1 reset state
    chk("R1 hcount", int'(hcount), 0);
    chk("R1 vcount", int'(vcount), 0);
    chk("R1 flag", int'(flag), 0);
    chk("R1 irq", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    run(130);                                   // R2 R3: 60 Hz frame wraps
    region = 1'b1; run(180);                    // R3: 50 Hz frame
    hen = 1'b1; hcmp = 9'd3; irq_en = 1'b1; run(60);   // R5 mode 01, R7
    ack = 1'b1; run(1); ack = 1'b0; run(15);    // R8
    hen = 1'b0; ven = 1'b1; vcmp = 9'd2;
    ack = 1'b1; run(1); ack = 1'b0;
    // R5: vertical-only match lands on horizontal zero
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (flag) break;
    end
    chk("R5 v-only flag", int'(flag), 1);
    chk("R5 v-only hcount", int'(hcount), 0);
    chk("R5 v-only vcount", int'(vcount), 2);
    hen = 1'b1; hcmp = 9'd5; vcmp = 9'd4; irq_en = 1'b0;
    ack = 1'b1; run(1); ack = 1'b0; run(200);   // R7: flag without arming
    irq_en = 1'b1; run(5);
    // R8: ack held so it meets a match edge
    ack = 1'b1; run(330); ack = 1'b0; run(10);
    // R9: unreachable horizontal position
    ven = 1'b0; hcmp = 9'd10;
    ack = 1'b1; run(1); ack = 1'b0;
    rises = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (flag) rises++;
    end
    chk("R9 no match beyond line end", rises, 0);
    // R4 linear mode with carries into vertical
    linear = 1'b1; hcmp = 9'd400; run(3300);
    ven = 1'b1; vcmp = 9'd3; hcmp = 9'd100; run(2200);
    linear = 1'b0; run(100);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule